// File: doc/BRIEF.md
# Transmit Descriptor Ring Run Controller

This block sequences a transmit DMA through a ring of descriptors held in memory. Software drives one level-sensitive run bit and supplies the ring base address. The controller fetches each descriptor over a simple request/response port and checks who owns it. If the DMA owns the descriptor, the controller hands the frame to the transmit datapath. It then waits for the datapath to report the frame complete, and moves on to the next descriptor slot.

The block has three exported states: Stopped, Running and Suspended. When it meets a descriptor the DMA does not own, it parks in Suspended and raises a sticky "transmit unavailable" flag. A poll pulse makes it look at that descriptor again. Clearing the run bit stops the block, but only once the frame in flight is finished. The position of the next descriptor is kept across a stop, so a later start carries on from that point. It does not rewind to the base.

Top module: `txdma_run_ctrl`

## Requirements
- R1: After reset, `run_state` is 0 (Stopped), `tx_unavail` is 0, and neither `desc_req` nor `frame_go` is asserted.
- R2: With `run_en` high in Stopped, the next clock edge sets `run_state` to 1 (Running) and raises `desc_req`. On the first start after reset, `desc_addr` is `list_base`.
- R3: When a fetch response arrives with `desc_rsp_own`=1, the next edge gives `run_state`=1 and a single-cycle `frame_go` pulse.
- R4: When a fetch response arrives with `desc_rsp_own`=0, the next edge gives `run_state`=2 (Suspended) and sets `tx_unavail`.
- R5: A `frame_done` pulse with `run_en` high advances the position by `DESC_BYTES`. The fetch for the new position is requested in the cycle right after that edge.
- R6: If the finished descriptor's response had `desc_rsp_eor`=1, the next position is the current `list_base` instead.
- R7: Dropping `run_en` during a frame leaves `run_state` at 1 until `frame_done`. The edge of `frame_done` moves it to 0.
- R8: In Suspended with no fetch outstanding, a low `run_en` moves `run_state` to 0 at the next edge.
- R9: A restart after a stop fetches from the retained position, even if `list_base` changed in between. That is the next slot after a completed frame, or the unowned slot after a stop from Suspended.
- R10: A high `run_en` issues no fetch outside Stopped. Suspended waits for a poll, and no `desc_req` occurs while Stopped.
- R11: A `poll_kick` pulse in Suspended re-fetches the same `desc_addr`. An owned response then returns the block to Running.
- R12: `tx_unavail` stays set until a `unavail_clr` pulse clears it. A new unowned response in the same cycle as the clear wins.
- R13: `run_state` never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Software run bit (1 = start/run, 0 = stop) |
| list_base | input | AW | Ring base address |
| poll_kick | input | 1 | Re-fetch pulse used in Suspended |
| unavail_clr | input | 1 | Write-1 clear of the unavailable flag |
| desc_req | output | 1 | Descriptor fetch request, one cycle |
| desc_addr | output | AW | Address of the current descriptor |
| desc_rsp_vld | input | 1 | Fetch response valid |
| desc_rsp_own | input | 1 | Descriptor is DMA-owned |
| desc_rsp_eor | input | 1 | Descriptor is the last slot of the ring |
| frame_go | output | 1 | Pulse: frame handed to the datapath |
| frame_done | input | 1 | Pulse: datapath finished the frame |
| run_state | output | 2 | 0 Stopped, 1 Running, 2 Suspended |
| tx_unavail | output | 1 | Sticky transmit-unavailable flag |

## Verification
Every result is due one edge after its cause. `run_state`, `frame_go` and `tx_unavail` follow the edge that samples a response, `frame_done`, `run_en` or `unavail_clr`. `desc_req` rises in the cycle after a start, a poll or a completed frame, and the response is only accepted one cycle after the request. The bench drives inputs just after a rising edge, advances exactly one edge, and samples there. The expected addresses come from base plus slot index times the descriptor size, and ownership and end-of-ring are swept over several laps of a four-slot ring.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    typedef enum logic [1:0] {
        TX_STOPPED   = 2'd0,
        TX_RUNNING   = 2'd1,
        TX_SUSPENDED = 2'd2
    } tx_run_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_WAIT  = 2'd2,
        PH_XMIT  = 2'd3
    } tx_phase_e;

    typedef struct packed {
        tx_run_e   run;
        tx_phase_e phase;
        logic      started;
        logic      eor;
        logic      go;
    } fsm_regs_t;

endpackage

// File: rtl/txdma_pos_track.sv
module txdma_pos_track #(
    parameter int AW         = 16,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] list_base,
    input  logic          load_base,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] pos
);
    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

    logic [AW-1:0] pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (load_base) begin
            pos_d = list_base;
        end else if (advance) begin
            pos_d = wrap ? list_base : pos_q + STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign pos = pos_q;

    // R5
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !wrap && !load_base) |=> (pos_q == $past(pos_q) + STEP));

    // R6
    ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && wrap) |=> (pos_q == $past(list_base)));

    // R9
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load_base) |=> $stable(pos_q));

endmodule

// File: rtl/txdma_unavail_flag.sv
module txdma_unavail_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set_i)      flag_d = 1'b1;
        else if (clr_i) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);

    // R12
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q);

    // R12
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && flag_q) |=> flag_q);

endmodule

// File: rtl/txdma_run_fsm.sv
module txdma_run_fsm
    import txdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       poll_kick,
    input  logic       desc_rsp_vld,
    input  logic       desc_rsp_own,
    input  logic       desc_rsp_eor,
    input  logic       frame_done,
    output logic       desc_req,
    output logic       frame_go,
    output logic       load_base,
    output logic       advance,
    output logic       wrap,
    output logic       set_unavail,
    output logic [1:0] run_state
);
    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        r_d.go      = 1'b0;
        load_base   = 1'b0;
        advance     = 1'b0;
        set_unavail = 1'b0;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (r_q.run == TX_STOPPED) begin
                    if (run_en) begin
                        r_d.run     = TX_RUNNING;
                        r_d.phase   = PH_ISSUE;
                        load_base   = !r_q.started;
                        r_d.started = 1'b1;
                    end
                end else if (r_q.run == TX_SUSPENDED) begin
                    if (!run_en) begin
                        r_d.run = TX_STOPPED;
                    end else if (poll_kick) begin
                        r_d.phase = PH_ISSUE;
                    end
                end
            end
            PH_ISSUE: begin
                r_d.phase = PH_WAIT;
            end
            PH_WAIT: begin
                if (desc_rsp_vld) begin
                    if (desc_rsp_own) begin
                        r_d.run   = TX_RUNNING;
                        r_d.phase = PH_XMIT;
                        r_d.eor   = desc_rsp_eor;
                        r_d.go    = 1'b1;
                    end else begin
                        r_d.run     = TX_SUSPENDED;
                        r_d.phase   = PH_IDLE;
                        set_unavail = 1'b1;
                    end
                end
            end
            PH_XMIT: begin
                if (frame_done) begin
                    advance = 1'b1;
                    if (run_en) begin
                        r_d.phase = PH_ISSUE;
                    end else begin
                        r_d.run   = TX_STOPPED;
                        r_d.phase = PH_IDLE;
                    end
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{run: TX_STOPPED, phase: PH_IDLE, started: 1'b0,
                     eor: 1'b0, go: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign desc_req  = (r_q.phase == PH_ISSUE);
    assign frame_go  = r_q.go;
    assign wrap      = r_q.eor;
    assign run_state = r_q.run;

    // R13
    state_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_state != 2'd3);

    // R3
    owned_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_WAIT && desc_rsp_vld && desc_rsp_own)
            |=> (frame_go && run_state == 2'd1));

    // R3
    go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_go |=> !frame_go);

    // R4
    unowned_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_WAIT && desc_rsp_vld && !desc_rsp_own)
            |=> (run_state == 2'd2 && !desc_req));

    // R7
    stop_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_XMIT && !frame_done) |=> (run_state == 2'd1));

    // R8
    susp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == 2'd2 && r_q.phase == PH_IDLE && !run_en)
            |=> (run_state == 2'd0));

    // R10
    no_fetch_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == 2'd0) |-> !desc_req);

    // R10
    susp_wait_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == 2'd2 && r_q.phase == PH_IDLE && !poll_kick)
            |=> !desc_req);

endmodule

// File: rtl/txdma_run_ctrl.sv
module txdma_run_ctrl #(
    parameter int AW         = 16,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [AW-1:0] list_base,
    input  logic          poll_kick,
    input  logic          unavail_clr,
    output logic          desc_req,
    output logic [AW-1:0] desc_addr,
    input  logic          desc_rsp_vld,
    input  logic          desc_rsp_own,
    input  logic          desc_rsp_eor,
    output logic          frame_go,
    input  logic          frame_done,
    output logic [1:0]    run_state,
    output logic          tx_unavail
);
    logic load_base, advance, wrap, set_unavail;

    txdma_run_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en       (run_en),
        .poll_kick    (poll_kick),
        .desc_rsp_vld (desc_rsp_vld),
        .desc_rsp_own (desc_rsp_own),
        .desc_rsp_eor (desc_rsp_eor),
        .frame_done   (frame_done),
        .desc_req     (desc_req),
        .frame_go     (frame_go),
        .load_base    (load_base),
        .advance      (advance),
        .wrap         (wrap),
        .set_unavail  (set_unavail),
        .run_state    (run_state)
    );

    txdma_pos_track #(
        .AW         (AW),
        .DESC_BYTES (DESC_BYTES)
    ) i_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .list_base (list_base),
        .load_base (load_base),
        .advance   (advance),
        .wrap      (wrap),
        .pos       (desc_addr)
    );

    txdma_unavail_flag i_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_unavail),
        .clr_i (unavail_clr),
        .flag  (tx_unavail)
    );

endmodule

// File: tb/test_txdma_run_ctrl.sv
module test_txdma_run_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int DB         = 16;
    localparam int RING       = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic [AW-1:0] list_base = 16'h0100;
    logic          poll_kick = 1'b0;
    logic          unavail_clr = 1'b0;
    logic          desc_req;
    logic [AW-1:0] desc_addr;
    logic          desc_rsp_vld = 1'b0;
    logic          desc_rsp_own = 1'b0;
    logic          desc_rsp_eor = 1'b0;
    logic          frame_go;
    logic          frame_done = 1'b0;
    logic [1:0]    run_state;
    logic          tx_unavail;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txdma_run_ctrl #(.AW(AW), .DESC_BYTES(DB)) i_txdma_run_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en       (run_en),
        .list_base    (list_base),
        .poll_kick    (poll_kick),
        .unavail_clr  (unavail_clr),
        .desc_req     (desc_req),
        .desc_addr    (desc_addr),
        .desc_rsp_vld (desc_rsp_vld),
        .desc_rsp_own (desc_rsp_own),
        .desc_rsp_eor (desc_rsp_eor),
        .frame_go     (frame_go),
        .frame_done   (frame_done),
        .run_state    (run_state),
        .tx_unavail   (tx_unavail)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // waits for a request, checks the address, answers it, checks the outcome
    task automatic fetch(input string req, input logic [AW-1:0] addr,
                         input logic own, input logic eor);
        for (int n = 0; n < 10 && !desc_req; n++) tick();
        chk(req, desc_req, 1);
        chk(req, desc_addr, addr);
        tick();
        desc_rsp_vld = 1'b1;
        desc_rsp_own = own;
        desc_rsp_eor = eor;
        tick();
        desc_rsp_vld = 1'b0;
        desc_rsp_own = 1'b0;
        desc_rsp_eor = 1'b0;
        if (own) begin
            chk("R3", frame_go, 1);
            chk("R3", run_state, 1);
        end else begin
            chk("R4", run_state, 2);
            chk("R4", tx_unavail, 1);
        end
    endtask

    task automatic end_frame();
        frame_done = 1'b1;
        tick();
        frame_done = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        finish_run();
    end

    initial begin
        tick();
        tick();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", run_state, 0);
        chk("R1", tx_unavail, 0);
        chk("R1", desc_req, 0);
        chk("R1", frame_go, 0);
        // R10 nothing while stopped and run bit low
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R10", desc_req, 0);
        end
        // R2 first start from base
        run_en = 1'b1;
        tick();
        chk("R2", run_state, 1);
        chk("R2", desc_req, 1);
        chk("R2", desc_addr, 16'h0100);
        // R5 R6 two laps of the ring
        for (int i = 0; i < 2 * RING; i++) begin
            fetch((i % RING == 0 && i > 0) ? "R6" : "R5",
                  AW'(16'h0100 + (i % RING) * DB), 1'b1, (i % RING) == RING - 1);
            tick();
            chk("R3", frame_go, 0);
            end_frame();
            chk("R5", desc_req, 1);
        end
        // slot 0 again, then R7 deferred stop
        fetch("R6", 16'h0100, 1'b1, 1'b0);
        run_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R7", run_state, 1);
        end
        end_frame();
        chk("R7", run_state, 0);
        chk("R7", desc_req, 0);
        // R9 resume at next slot although base moved
        list_base = 16'h0800;
        tick();
        chk("R10", desc_req, 0);
        run_en = 1'b1;
        tick();
        chk("R9", run_state, 1);
        fetch("R9", 16'h0110, 1'b0, 1'b0);
        // R10 run bit held high in Suspended: no fetch
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R10", desc_req, 0);
            chk("R12", tx_unavail, 1);
        end
        unavail_clr = 1'b1;
        tick();
        unavail_clr = 1'b0;
        chk("R12", tx_unavail, 0);
        // R11 poll: unowned again, then owned
        poll_kick = 1'b1;
        tick();
        poll_kick = 1'b0;
        chk("R11", desc_req, 1);
        fetch("R11", 16'h0110, 1'b0, 1'b0);
        unavail_clr = 1'b1;
        tick();
        unavail_clr = 1'b0;
        poll_kick = 1'b1;
        tick();
        poll_kick = 1'b0;
        fetch("R11", 16'h0110, 1'b1, 1'b0);
        chk("R11", run_state, 1);
        end_frame();
        // R12 set and clear in the same cycle: set wins
        chk("R5", desc_addr, 16'h0120);
        tick();
        desc_rsp_vld = 1'b1;
        desc_rsp_own = 1'b0;
        unavail_clr = 1'b1;
        tick();
        desc_rsp_vld = 1'b0;
        unavail_clr = 1'b0;
        chk("R12", tx_unavail, 1);
        chk("R4", run_state, 2);
        // R8 immediate stop from Suspended
        run_en = 1'b0;
        tick();
        chk("R8", run_state, 0);
        // R9 restart retries the unowned slot
        run_en = 1'b1;
        tick();
        fetch("R9", 16'h0120, 1'b1, 1'b0);
        end_frame();
        fetch("R5", 16'h0130, 1'b1, 1'b1);
        end_frame();
        // R6 wrap to the new base
        chk("R6", desc_addr, 16'h0800);
        chk("R13", {31'd0, run_state != 2'd3}, 1);
        finish_run();
    end
endmodule